// File: doc/BRIEF.md
# Keyed System Configuration Register Block

This block keeps the chip-level configuration word that decides which functions own the shared pin groups. It also carries a read-only identification word with the silicon revision and the software reset control. All of it sits on a simple synchronous word-addressed bus. A bus write updates the configuration word only when it comes straight after a key write to the gate register. Any other write order leaves the word untouched and marks the attempt in a sticky error flag. The next configuration write closes the gate again.

Software updates the configuration word by read-modify-write. It reads the word, changes the bits it needs, writes the key and then writes the new value back. A system reset is requested by writing the word with the reset bit set and, under a fresh key, writing it again with that bit cleared. The block then emits a one-cycle request pulse. The pin multiplexers and the reset distribution lie outside the block. They consume `cfg_word` and `reset_req`.

Top module: `sysctl_keyed_regs`

## Requirements
- R1: After reset, `cfg_word` equals 32'h0801C002, `err_flag` and `reset_req` are 0, and the gate is closed. The default sets the keypad pin group to GPIO (bits 1 and 27) and the storage-interface pin groups to GPIO (bits 14, 15, 16), and clears the coprocessor-enable bit (bit 23).
- R2: A write of exactly 32'h000000AA to the gate register (word 2) opens the gate. A read of word 2 returns 32'h1 while the gate is open and 32'h0 while it is closed.
- R3: A write to the configuration word (word 0) while the gate is open loads `bus_wdata` into `cfg_word` on that clock edge and closes the gate. A second write without a new key is not accepted.
- R4: A write to word 2 with any value other than 32'h000000AA closes the gate.
- R5: A write to word 0 while the gate is closed leaves `cfg_word` unchanged and sets `err_flag`. The flag reads as bit 0 of word 3 and stays set until reset.
- R6: Writes to word 1, to word 3 and to unmapped words change neither `cfg_word` nor the gate state.
- R7: Word 1 reads the revision parameter (default 5) in bits [31:28] and zeros elsewhere. Writes to word 1 have no effect on it.
- R8: `reset_req` is high for exactly one cycle, the cycle after an accepted word-0 write that clears bit 31 while bit 31 was set. No pulse follows the setting of the bit, and none follows a clear attempt while the gate is closed.
- R9: A read of word 0 returns the current `cfg_word` in the same cycle, so a read-modify-write of the word takes effect as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address; 0 when not selected |
| cfg_word | output | 32 | Configuration word driving pin-group ownership |
| err_flag | output | 1 | Sticky flag for a configuration write made while the gate was closed |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A wrong gate state shows up as soon as one access touches it. A gate left open appears as a read of 1 on word 2 and as an accepted second write to word 0. A gate closed too early appears on the next edge as an unchanged `cfg_word` and a raised `err_flag`. A wrong edge tracker for the reset bit shows up in the cycle after the clearing write: a pulse is missing, lasts two cycles, or appears after a rejected or setting write. The bench model is compared with `cfg_word`, `err_flag` and `reset_req` on every clock, so any divergence is seen within one cycle of the write that caused it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned SC_W     = 32;
  localparam int unsigned SC_KEY_W = 8;

  // word indices of the register map
  localparam int unsigned SC_IDX_CFG = 0;
  localparam int unsigned SC_IDX_ID  = 1;
  localparam int unsigned SC_IDX_KEY = 2;
  localparam int unsigned SC_IDX_ERR = 3;

  // configuration word field positions
  localparam int unsigned SC_BIT_KPD_GPIO   = 1;
  localparam int unsigned SC_BIT_STOR_A     = 14;
  localparam int unsigned SC_BIT_STOR_B     = 15;
  localparam int unsigned SC_BIT_STOR_C     = 16;
  localparam int unsigned SC_BIT_COPROC_EN  = 23;
  localparam int unsigned SC_BIT_KPD_PORT   = 27;
  localparam int unsigned SC_BIT_SWRST      = 31;

  localparam logic [SC_W-1:0] SC_CFG_DEFAULT =
      (SC_W'(1) << SC_BIT_KPD_GPIO) |
      (SC_W'(1) << SC_BIT_KPD_PORT) |
      (SC_W'(1) << SC_BIT_STOR_A)   |
      (SC_W'(1) << SC_BIT_STOR_B)   |
      (SC_W'(1) << SC_BIT_STOR_C);

  typedef struct packed {
    logic cfg;
    logic id;
    logic key;
    logic err;
  } sc_hit_t;

  function automatic logic sc_key_ok(input logic [SC_W-1:0] d,
                                     input logic [SC_KEY_W-1:0] key);
    return d == {{(SC_W-SC_KEY_W){1'b0}}, key};
  endfunction

  function automatic logic [SC_W-1:0] sc_id_word(input logic [SC_W-1:0] rev,
                                                 input int unsigned lsb);
    return rev << lsb;
  endfunction

  function automatic logic sc_falls(input logic was_set, input logic next_val);
    return was_set && !next_val;
  endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output sc_hit_t           wr_hit,
  output sc_hit_t           rd_hit
);

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(SC_IDX_CFG);
  localparam logic [ADDR_W-1:0] A_ID  = ADDR_W'(SC_IDX_ID);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(SC_IDX_KEY);
  localparam logic [ADDR_W-1:0] A_ERR = ADDR_W'(SC_IDX_ERR);

  sc_hit_t hit;

  always_comb begin
    hit.cfg = (addr == A_CFG);
    hit.id  = (addr == A_ID);
    hit.key = (addr == A_KEY);
    hit.err = (addr == A_ERR);
  end

  assign wr_hit = (sel && wr)  ? hit : '0;
  assign rd_hit = (sel && !wr) ? hit : '0;

endmodule

// File: rtl/sysctl_key_gate.sv
module sysctl_key_gate
  import sysctl_pkg::*;
#(
  parameter logic [SC_KEY_W-1:0] KEY_VAL = 8'hAA
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            key_wr,
  input  logic            prot_wr,
  input  logic [SC_W-1:0] wdata,
  output logic            open_q,
  output logic            accept,
  output logic            viol
);

  logic open_d;

  always_comb begin
    open_d = open_q;
    if (prot_wr)
      open_d = 1'b0;
    else if (key_wr)
      open_d = sc_key_ok(wdata, KEY_VAL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign accept = prot_wr && open_q;
  assign viol   = prot_wr && !open_q;

endmodule

// File: rtl/sysctl_cfg_core.sv
module sysctl_cfg_core
  import sysctl_pkg::*;
#(
  parameter logic [SC_W-1:0] CFG_INIT  = SC_CFG_DEFAULT,
  parameter int unsigned     SWRST_BIT = SC_BIT_SWRST
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            viol,
  input  logic [SC_W-1:0] wdata,
  output logic [SC_W-1:0] cfg_q,
  output logic            err_q,
  output logic            pulse_q,
  output logic            fall_ev
);

  logic armed_q;

  assign fall_ev = accept && sc_falls(armed_q, wdata[SWRST_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= CFG_INIT;
      armed_q <= CFG_INIT[SWRST_BIT];
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= fall_ev;
      if (accept) begin
        cfg_q   <= wdata;
        armed_q <= wdata[SWRST_BIT];
      end
      if (viol) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
  import sysctl_pkg::*;
#(
  parameter int unsigned      REV_W   = 4,
  parameter logic [REV_W-1:0] REV_VAL = 4'h5,
  parameter int unsigned      REV_LSB = 28
) (
  input  sc_hit_t         rd_hit,
  input  logic [SC_W-1:0] cfg_q,
  input  logic            open_q,
  input  logic            err_q,
  output logic [SC_W-1:0] rdata
);

  localparam logic [SC_W-1:0] ID_WORD = sc_id_word(SC_W'(REV_VAL), REV_LSB);

  always_comb begin
    rdata = '0;
    unique case (1'b1)
      rd_hit.cfg: rdata = cfg_q;
      rd_hit.id:  rdata = ID_WORD;
      rd_hit.key: rdata = {{(SC_W-1){1'b0}}, open_q};
      rd_hit.err: rdata = {{(SC_W-1){1'b0}}, err_q};
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/sysctl_keyed_regs.sv
module sysctl_keyed_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned         ADDR_W    = 4,
  parameter logic [SC_KEY_W-1:0] KEY_VAL   = 8'hAA,
  parameter int unsigned         REV_W     = 4,
  parameter logic [REV_W-1:0]    REV_VAL   = 4'h5,
  parameter int unsigned         REV_LSB   = 28,
  parameter int unsigned         SWRST_BIT = SC_BIT_SWRST,
  parameter logic [SC_W-1:0]     CFG_INIT  = SC_CFG_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SC_W-1:0]   bus_wdata,
  output logic [SC_W-1:0]   bus_rdata,
  output logic [SC_W-1:0]   cfg_word,
  output logic              err_flag,
  output logic              reset_req
);

  sc_hit_t wr_hit;
  sc_hit_t rd_hit;

  // named internal events, used by the bound checker
  logic gate_open;
  logic prot_wr_ev;
  logic accept_ev;
  logic viol_ev;
  logic fall_ev;

  assign prot_wr_ev = wr_hit.cfg;

  sysctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  sysctl_key_gate #(.KEY_VAL(KEY_VAL)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (wr_hit.key),
    .prot_wr (prot_wr_ev),
    .wdata   (bus_wdata),
    .open_q  (gate_open),
    .accept  (accept_ev),
    .viol    (viol_ev)
  );

  sysctl_cfg_core #(.CFG_INIT(CFG_INIT), .SWRST_BIT(SWRST_BIT)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept_ev),
    .viol    (viol_ev),
    .wdata   (bus_wdata),
    .cfg_q   (cfg_word),
    .err_q   (err_flag),
    .pulse_q (reset_req),
    .fall_ev (fall_ev)
  );

  sysctl_rd_mux #(.REV_W(REV_W), .REV_VAL(REV_VAL), .REV_LSB(REV_LSB)) u_rd (
    .rd_hit (rd_hit),
    .cfg_q  (cfg_word),
    .open_q (gate_open),
    .err_q  (err_flag),
    .rdata  (bus_rdata)
  );

endmodule

// File: rtl/sysctl_keyed_regs_chk.sv
module sysctl_keyed_regs_chk
  import sysctl_pkg::*;
#(
  parameter int unsigned         ADDR_W    = 4,
  parameter logic [SC_KEY_W-1:0] KEY_VAL   = 8'hAA,
  parameter int unsigned         SWRST_BIT = SC_BIT_SWRST
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SC_W-1:0]   bus_wdata,
  input logic [SC_W-1:0]   cfg_word,
  input logic              err_flag,
  input logic              reset_req,
  input logic              gate_open,
  input logic              prot_wr_ev,
  input logic              accept_ev
);

  logic wr_any, key_wr, side_wr, good_key;
  assign wr_any   = bus_sel && bus_wr;
  assign key_wr   = wr_any && (bus_addr == ADDR_W'(SC_IDX_KEY));
  assign side_wr  = wr_any && ((bus_addr == ADDR_W'(SC_IDX_ID)) ||
                               (bus_addr == ADDR_W'(SC_IDX_ERR)));
  assign good_key = (bus_wdata == {{(SC_W-SC_KEY_W){1'b0}}, KEY_VAL});

  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && good_key |=> gate_open);

  a_r3_gate_closes: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr_ev |=> !gate_open);

  a_r3_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> cfg_word == $past(bus_wdata));

  a_r4_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr && !good_key |=> !gate_open);

  a_r5_locked_held: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr_ev && !gate_open |=> $stable(cfg_word) && err_flag);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r6_side_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    side_wr |=> $stable(cfg_word) && $stable(gate_open));

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(accept_ev) && $past(cfg_word[SWRST_BIT]) && !cfg_word[SWRST_BIT]);

endmodule

bind sysctl_keyed_regs sysctl_keyed_regs_chk #(
  .ADDR_W(ADDR_W), .KEY_VAL(KEY_VAL), .SWRST_BIT(SWRST_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .cfg_word   (cfg_word),
  .err_flag   (err_flag),
  .reset_req  (reset_req),
  .gate_open  (gate_open),
  .prot_wr_ev (prot_wr_ev),
  .accept_ev  (accept_ev)
);

// File: tb/sysctl_keyed_regs_tb.sv
`timescale 1ns/1ps
module sysctl_keyed_regs_tb;

  localparam logic [31:0] EXP_INIT = 32'h0801C002;
  localparam logic [31:0] EXP_ID   = 32'h5000_0000;
  localparam logic [31:0] KEY      = 32'h0000_00AA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] cfg_word;
  logic        err_flag;
  logic        reset_req;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [31:0] m_cfg;
  logic        m_open, m_err, m_pulse;
  int          pulse_log[$];

  always #2.5 clk = ~clk;

  sysctl_keyed_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_word(cfg_word), .err_flag(err_flag), .reset_req(reset_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = EXP_INIT; m_open = 1'b0; m_err = 1'b0; m_pulse = 1'b0;
    end else begin
      m_pulse = 1'b0;
      if (bus_sel && bus_wr) begin
        if (bus_addr == 4'd0) begin
          if (m_open) begin
            if (m_cfg[31] && !bus_wdata[31]) begin
              m_pulse = 1'b1;
              pulse_log.push_back(1);
            end
            m_cfg = bus_wdata;
          end else begin
            m_err = 1'b1;
          end
          m_open = 1'b0;
        end else if (bus_addr == 4'd2) begin
          m_open = (bus_wdata == KEY);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "model cfg_word", cfg_word, m_cfg);
      chk(cur_req, "model err_flag", {31'b0, err_flag}, {31'b0, m_err});
      chk(cur_req, "model reset_req", {31'b0, reset_req}, {31'b0, m_pulse});
    end
  end

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [31:0] exp,
                         input string req, input string what);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(req, what, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic read_now(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "cfg after reset", cfg_word, EXP_INIT);
    chk("R1", "err after reset", {31'b0, err_flag}, 32'h0);
    chk("R1", "pulse after reset", {31'b0, reset_req}, 32'h0);
    do_read(4'd2, 32'h0, "R1", "gate closed after reset");

    // R7: identification word
    cur_req = "R7";
    do_read(4'd1, EXP_ID, "R7", "id word");
    do_write(4'd1, 32'hFFFF_FFFF);
    do_read(4'd1, EXP_ID, "R7", "id word after write");

    // R5: locked write rejected, error sticky
    cur_req = "R5";
    do_write(4'd0, 32'h1234_5678);
    chk("R5", "cfg unchanged when locked", cfg_word, EXP_INIT);
    do_read(4'd3, 32'h1, "R5", "error flag word");

    // R2: key opens gate
    cur_req = "R2";
    do_write(4'd2, KEY);
    do_read(4'd2, 32'h1, "R2", "gate open after key");

    // R6: side writes leave gate and cfg alone
    cur_req = "R6";
    do_write(4'd1, 32'h0);
    do_write(4'd3, 32'h0);
    do_write(4'd9, 32'hDEAD_BEEF);
    do_read(4'd2, 32'h1, "R6", "gate still open after side writes");
    chk("R6", "cfg after side writes", cfg_word, EXP_INIT);
    do_read(4'd3, 32'h1, "R6", "error flag after word 3 write");

    // R3: accepted write then gate closes
    cur_req = "R3";
    do_write(4'd0, 32'h00A5_0F0F);
    chk("R3", "cfg loaded", cfg_word, 32'h00A5_0F0F);
    do_read(4'd2, 32'h0, "R3", "gate closed after accept");
    do_write(4'd0, 32'h0000_0001);
    chk("R3", "second write rejected", cfg_word, 32'h00A5_0F0F);

    // R4: wrong keys close the gate
    cur_req = "R4";
    do_write(4'd2, KEY);
    do_write(4'd2, 32'h0000_00AB);
    do_read(4'd2, 32'h0, "R4", "gate closed by 0xAB");
    do_write(4'd2, KEY);
    do_write(4'd2, 32'h0000_01AA);
    do_read(4'd2, 32'h0, "R4", "gate closed by 0x1AA");
    do_write(4'd0, 32'h0);
    chk("R4", "cfg kept after bad key", cfg_word, 32'h00A5_0F0F);

    // R9: read-modify-write
    cur_req = "R9";
    read_now(4'd0, v);
    chk("R9", "read returns cfg", v, 32'h00A5_0F0F);
    do_write(4'd2, KEY);
    do_write(4'd0, (v | 32'h0080_0000) & ~32'h0000_0002);
    do_read(4'd0, 32'h00A5_0F0D, "R9", "rmw result");

    // R8: set then clear reset bit
    cur_req = "R8";
    do_write(4'd2, KEY);
    do_write(4'd0, 32'h8000_0003);
    #1 chk("R8", "no pulse on set", {31'b0, reset_req}, 32'h0);
    do_write(4'd2, KEY);
    do_write(4'd0, 32'h0000_0003);
    #1 chk("R8", "pulse after clear", {31'b0, reset_req}, 32'h1);
    @(negedge clk); #1
    chk("R8", "pulse one cycle", {31'b0, reset_req}, 32'h0);
    chk("R8", "one pulse logged", pulse_log.size(), 32'd1);
    // clear without key: no pulse
    do_write(4'd2, KEY);
    do_write(4'd0, 32'h8000_0000);
    do_write(4'd0, 32'h0000_0000);
    #1 chk("R8", "no pulse when locked", {31'b0, reset_req}, 32'h0);
    chk("R8", "bit stays set", cfg_word, 32'h8000_0000);
    repeat (3) @(negedge clk);
    chk("R8", "pulse count unchanged", pulse_log.size(), 32'd1);

    cur_req = "R5";
    do_read(4'd3, 32'h1, "R5", "error flag still set");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule